// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block arbitrates eight interrupt request lines. It keeps a request register, fed by the lines through a trigger mode chosen per line (edge or level), and an in-service register. The mask arrives as an input vector. Each cycle it finds the highest-priority unmasked request under a rotating priority order, and the highest-priority line in service under the same order. It raises its interrupt output only when the request outranks everything in service.

An acknowledge strobe, carrying a 3-bit line index, marks that line as in service or, in automatic end-of-interrupt mode, leaves the in-service register alone and can move the rotation so the acknowledged line becomes lowest priority. The mode flags are plain inputs: special mask, fully nested, master, automatic end-of-interrupt and rotate on automatic end-of-interrupt. Programming those flags and the mask belongs to the surrounding logic.

Top module: `prio_resolver`

## Requirements
- R1: Reset clears the request, in-service, last-level and rotation registers and sets every line to edge mode (trigger mode bit 0). After reset, with no requests, `int_out` is 0 and `win_line` is 0.
- R2: The trigger mode register samples `trig_mode_in` at every clock; bit value 1 means level mode. A level-mode line copies its input into its request bit at each clock, and an acknowledge does not clear it.
- R3: An edge-mode line sets its request bit at a clock where its input is 1 and the previously sampled level was 0. The bit stays set when the input falls. An acknowledge of that line clears it, unless a new rising edge arrives in the same cycle. An input held high does not set the bit again.
- R4: The pending set is the request register with masked lines (`mask_in` bit 1) removed; an empty pending set keeps `int_out` at 0.
- R5: Priority rank 0 is the highest. Rank p belongs to line (p + rotation) mod 8, and the pending winner is the set line of lowest rank.
- R6: `int_out` is 1 only when the pending winner's rank is strictly less than the rank of the highest-priority line in service. `win_line` gives the winner's line number while `int_out` is 1 and 0 otherwise.
- R7: With `special_mask` set, masked lines are left out of the in-service register before its rank is computed.
- R8: With both `is_master` and `nested_mode` set, in-service bit 2 is left out of the in-service rank; with either flag clear it counts.
- R9: An acknowledge with `auto_eoi` 0 sets the in-service bit of `ack_line`.
- R10: An acknowledge with `auto_eoi` 1 leaves the in-service register unchanged. With `rotate_aeoi` also 1, the rotation becomes (`ack_line` + 1) mod 8, wrapping from 7 to 0. Otherwise the rotation does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in | input | 8 | Interrupt request lines |
| trig_mode_in | input | 8 | Trigger mode per line, 1 = level, 0 = edge |
| mask_in | input | 8 | Mask per line, 1 = masked |
| special_mask | input | 1 | Drop masked lines from the in-service rank |
| nested_mode | input | 1 | Fully nested mode flag |
| is_master | input | 1 | Instance is a master (cascade on line 2) |
| auto_eoi | input | 1 | Automatic end-of-interrupt on acknowledge |
| rotate_aeoi | input | 1 | Rotate priority on automatic end-of-interrupt |
| ack_valid | input | 1 | Single-cycle acknowledge strobe |
| ack_line | input | 3 | Line being acknowledged |
| int_out | output | 1 | Interrupt request to the processor side |
| win_line | output | 3 | Winning line number |

## Verification
The assertions watch, on every cycle, that a raised output always names an unmasked, requested line, that an empty pending set never raises it, that level lines mirror their inputs, and that acknowledges touch the in-service register and the rotation exactly as the modes say. Only the bench's scenarios can show the ordering results: rotation wraparound from line 7 back to 0, a higher-priority request breaking into a service in progress while a lower one stays blocked, the special-mask and fully-nested exclusions, and the difference between an edge line that ignores a held-high input and a level line that re-requests after acknowledge. A behavioural reference model in the bench checks both outputs every cycle.

// File: rtl/prio_res_pkg.sv
package prio_res_pkg;

    localparam int unsigned DEF_LINES = 8;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_mode_e;

endpackage

// File: rtl/prio_rank_search.sv
module prio_rank_search #(
    parameter int unsigned N_LINES = 8,
    localparam int unsigned IDX_W  = $clog2(N_LINES),
    localparam int unsigned RANK_W = IDX_W + 1
) (
    input  logic [N_LINES-1:0] bits_in,
    input  logic [IDX_W-1:0]   offset,
    output logic [RANK_W-1:0]  rank
);

    logic [N_LINES-1:0] by_rank;

    // by_rank[p] is the line that holds rank p under the current rotation
    for (genvar p = 0; p < N_LINES; p++) begin : g_rot
        logic [IDX_W-1:0] sel;
        assign sel        = IDX_W'(p) + offset;
        assign by_rank[p] = bits_in[sel];
    end

    always_comb begin
        rank = RANK_W'(N_LINES);
        for (int p = N_LINES - 1; p >= 0; p--) begin
            if (by_rank[p]) begin
                rank = RANK_W'(p);
            end
        end
    end

endmodule

// File: rtl/prio_req_line.sv
module prio_req_line
    import prio_res_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  trig_mode_e mode,
    input  logic       ack_hit,
    output logic       pend
);

    logic last_q;
    logic pend_d;

    always_comb begin
        unique case (mode)
            TRIG_LEVEL: pend_d = req;
            TRIG_EDGE: begin
                if (req && !last_q) begin
                    pend_d = 1'b1;
                end else if (ack_hit) begin
                    pend_d = 1'b0;
                end else begin
                    pend_d = pend;
                end
            end
            default: pend_d = pend;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= 1'b0;
            pend   <= 1'b0;
        end else begin
            last_q <= req;
            pend   <= pend_d;
        end
    end

endmodule

// File: rtl/prio_resolver.sv
module prio_resolver
    import prio_res_pkg::*;
#(
    parameter int unsigned N_LINES      = DEF_LINES,
    parameter int unsigned CASCADE_LINE = 2,
    localparam int unsigned IDX_W       = $clog2(N_LINES),
    localparam int unsigned RANK_W      = IDX_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] req_in,
    input  logic [N_LINES-1:0] trig_mode_in,
    input  logic [N_LINES-1:0] mask_in,
    input  logic               special_mask,
    input  logic               nested_mode,
    input  logic               is_master,
    input  logic               auto_eoi,
    input  logic               rotate_aeoi,
    input  logic               ack_valid,
    input  logic [IDX_W-1:0]   ack_line,
    output logic               int_out,
    output logic [IDX_W-1:0]   win_line
);

    logic [N_LINES-1:0] mode_q;
    logic [N_LINES-1:0] isr_q;
    logic [IDX_W-1:0]   offset_q;
    logic [N_LINES-1:0] irr_vec;
    logic [N_LINES-1:0] ack_hit;
    logic [N_LINES-1:0] pend_vec;
    logic [N_LINES-1:0] isr_view;
    logic [RANK_W-1:0]  pend_rank;
    logic [RANK_W-1:0]  svc_rank;

    always_comb begin
        ack_hit = '0;
        if (ack_valid) begin
            ack_hit[ack_line] = 1'b1;
        end
    end

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        prio_req_line u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (req_in[i]),
            .mode    (trig_mode_e'(mode_q[i])),
            .ack_hit (ack_hit[i]),
            .pend    (irr_vec[i])
        );
    end

    assign pend_vec = irr_vec & ~mask_in;

    always_comb begin
        isr_view = isr_q;
        if (special_mask) begin
            isr_view = isr_view & ~mask_in;
        end
        if (is_master && nested_mode) begin
            isr_view[CASCADE_LINE] = 1'b0;
        end
    end

    prio_rank_search #(.N_LINES(N_LINES)) u_pend_search (
        .bits_in (pend_vec),
        .offset  (offset_q),
        .rank    (pend_rank)
    );

    prio_rank_search #(.N_LINES(N_LINES)) u_svc_search (
        .bits_in (isr_view),
        .offset  (offset_q),
        .rank    (svc_rank)
    );

    // state register: trigger modes, in-service set, rotation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= '0;
            isr_q    <= '0;
            offset_q <= '0;
        end else begin
            mode_q <= trig_mode_in;
            if (ack_valid) begin
                if (auto_eoi) begin
                    if (rotate_aeoi) begin
                        offset_q <= ack_line + 1'b1;
                    end
                end else begin
                    isr_q[ack_line] <= 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        int_out  = (pend_rank < svc_rank);
        win_line = int_out ? (pend_rank[IDX_W-1:0] + offset_q) : '0;
    end

endmodule

// File: rtl/prio_resolver_chk.sv
module prio_resolver_chk #(
    parameter int unsigned N_LINES = 8,
    localparam int unsigned IDX_W  = $clog2(N_LINES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_LINES-1:0] req_in,
    input logic [N_LINES-1:0] mask_in,
    input logic               auto_eoi,
    input logic               rotate_aeoi,
    input logic               ack_valid,
    input logic [IDX_W-1:0]   ack_line,
    input logic               int_out,
    input logic [IDX_W-1:0]   win_line,
    input logic [N_LINES-1:0] irr_vec,
    input logic [N_LINES-1:0] isr_q,
    input logic [IDX_W-1:0]   offset_q,
    input logic [N_LINES-1:0] mode_q
);

    logic [IDX_W-1:0] ack_next;
    assign ack_next = ack_line + 1'b1;

    p_win_is_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> (irr_vec[win_line] && !mask_in[win_line]));

    p_quiet_when_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((irr_vec & ~mask_in) == '0) |-> !int_out);

    p_level_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irr_vec & $past(mode_q)) == ($past(req_in) & $past(mode_q))));

    p_ack_sets_isr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !auto_eoi) |=> isr_q[$past(ack_line)]);

    p_aeoi_keeps_isr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && auto_eoi) |=> $stable(isr_q));

    p_rotate_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && auto_eoi && rotate_aeoi) |=> (offset_q == $past(ack_next)));

    p_rotate_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_valid && auto_eoi && rotate_aeoi) |=> $stable(offset_q));

endmodule

bind prio_resolver prio_resolver_chk #(.N_LINES(N_LINES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_in      (req_in),
    .mask_in     (mask_in),
    .auto_eoi    (auto_eoi),
    .rotate_aeoi (rotate_aeoi),
    .ack_valid   (ack_valid),
    .ack_line    (ack_line),
    .int_out     (int_out),
    .win_line    (win_line),
    .irr_vec     (irr_vec),
    .isr_q       (isr_q),
    .offset_q    (offset_q),
    .mode_q      (mode_q)
);

// File: tb/sim_prio_resolver.sv
module sim_prio_resolver;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_in = '0;
    logic [7:0] trig_mode_in = '0;
    logic [7:0] mask_in = '0;
    logic       special_mask = 1'b0;
    logic       nested_mode = 1'b0;
    logic       is_master = 1'b0;
    logic       auto_eoi = 1'b0;
    logic       rotate_aeoi = 1'b0;
    logic       ack_valid = 1'b0;
    logic [2:0] ack_line = '0;
    logic       int_out;
    logic [2:0] win_line;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    prio_resolver u0 (.*);

    // behavioural reference model
    bit [7:0] m_irr, m_last, m_mode, m_isr;
    int m_off;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_irr = 0; m_last = 0; m_mode = 0; m_isr = 0; m_off = 0;
        end else begin
            for (int i = 0; i < 8; i++) begin
                if (m_mode[i]) m_irr[i] = req_in[i];
                else if (req_in[i] && !m_last[i]) m_irr[i] = 1'b1;
                else if (ack_valid && ack_line == i) m_irr[i] = 1'b0;
            end
            m_last = req_in;
            if (ack_valid) begin
                if (auto_eoi) begin
                    if (rotate_aeoi) m_off = (int'(ack_line) + 1) % 8;
                end else begin
                    m_isr[ack_line] = 1'b1;
                end
            end
            m_mode = trig_mode_in;
        end
    end

    function automatic int rank_of(bit [7:0] v, int off);
        for (int p = 0; p < 8; p++) if (v[(p + off) % 8]) return p;
        return 8;
    endfunction

    task automatic model_out(output bit e_int, output bit [2:0] e_win);
        bit [7:0] sv;
        int pr, sr;
        sv = m_isr;
        if (special_mask) sv = sv & ~mask_in;
        if (is_master && nested_mode) sv[2] = 1'b0;
        pr = rank_of(m_irr & ~mask_in, m_off);
        sr = rank_of(sv, m_off);
        e_int = (pr < sr);
        e_win = e_int ? 3'((pr + m_off) % 8) : 3'd0;
    endtask

    // per-cycle comparison against the model (R6 output rule)
    always @(negedge clk) begin
        bit ei;
        bit [2:0] ew;
        #2;
        if (rst_n && !done) begin
            model_out(ei, ew);
            n_cmp++;
            if (int_out !== ei || win_line !== ew) begin
                n_bad++;
                $display("FAIL R6 model t=%0t: int/win actual %0b/%0d expected %0b/%0d",
                         $time, int_out, win_line, ei, ew);
            end
        end
    end

    task automatic chk(bit ei, bit [2:0] ew, string tag);
        n_cmp++;
        if (int_out !== ei || win_line !== ew) begin
            n_bad++;
            $display("FAIL %s: int/win actual %0b/%0d expected %0b/%0d",
                     tag, int_out, win_line, ei, ew);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle();
        #3;
    endtask

    task automatic do_reset();
        tick(1);
        rst_n = 1'b0;
        req_in = '0; trig_mode_in = '0; mask_in = '0;
        special_mask = 0; nested_mode = 0; is_master = 0;
        auto_eoi = 0; rotate_aeoi = 0; ack_valid = 0; ack_line = '0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic do_ack(bit [2:0] ln);
        tick(1);
        ack_valid = 1'b1;
        ack_line = ln;
        tick(1);
        ack_valid = 1'b0;
        settle();
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        settle();
        chk(0, 0, "R1 after reset");

        // R3 edge triggering
        tick(1); auto_eoi = 1; req_in[3] = 1;
        tick(2); settle(); chk(1, 3, "R3 rising edge latches");
        do_ack(3); chk(0, 0, "R3 held high does not retrigger");
        tick(1); req_in[3] = 0;
        tick(1); req_in[3] = 1;
        tick(2); settle(); chk(1, 3, "R3 new edge relatches");
        do_ack(3); tick(1); req_in[3] = 0;
        req_in[6] = 1; tick(2); req_in[6] = 0; tick(2); settle();
        chk(1, 6, "R3 bit stays after input falls");
        do_ack(6); chk(0, 0, "R3 ack clears edge line");

        // R2 level triggering
        tick(1); trig_mode_in[5] = 1; req_in[5] = 1;
        tick(2); settle(); chk(1, 5, "R2 level request");
        do_ack(5); chk(1, 5, "R2 ack keeps level bit");
        tick(1); req_in[5] = 0;
        tick(1); settle(); chk(0, 0, "R2 level bit follows low input");

        // R4 masking
        do_reset();
        mask_in[1] = 1; req_in[1] = 1;
        tick(2); settle(); chk(0, 0, "R4 masked request blocked");
        tick(1); mask_in[1] = 0; settle(); chk(1, 1, "R4 unmasked request shows");

        // R5 / R10 rotation
        do_reset();
        auto_eoi = 1; rotate_aeoi = 1;
        trig_mode_in[0] = 1; trig_mode_in[7] = 1; req_in[0] = 1; req_in[7] = 1;
        tick(2); settle(); chk(1, 0, "R5 offset 0 picks line 0");
        do_ack(0); chk(1, 7, "R5 offset 1 picks line 7");
        do_ack(7); chk(1, 0, "R10 rotation wraps 7 to 0");
        tick(1); rotate_aeoi = 0;
        do_ack(0); chk(1, 0, "R10 no rotation without rotate flag");
        tick(1); rotate_aeoi = 1;
        do_ack(3); chk(1, 7, "R5 offset 4 picks line 7");

        // R1 reset returns rotation to 0
        do_reset();
        req_in[0] = 1; req_in[7] = 1;
        tick(2); settle(); chk(1, 0, "R1 rotation cleared by reset");

        // R9 / R6 nested service
        do_reset();
        req_in[4] = 1;
        tick(2); settle(); chk(1, 4, "R6 line 4 requested");
        do_ack(4); chk(0, 0, "R9 line 4 in service blocks itself");
        tick(1); req_in[6] = 1;
        tick(2); settle(); chk(0, 0, "R6 lower priority blocked");
        tick(1); req_in[2] = 1;
        tick(2); settle(); chk(1, 2, "R6 higher priority breaks in");

        // R7 special mask
        tick(1); mask_in = 8'b0001_0100; settle();
        chk(0, 0, "R7 without special mask service blocks");
        tick(1); special_mask = 1; settle();
        chk(1, 6, "R7 special mask drops masked service");

        // R8 fully nested on master
        do_reset();
        trig_mode_in[2] = 1; req_in[2] = 1;
        tick(2); settle(); chk(1, 2, "R8 line 2 level request");
        do_ack(2); chk(0, 0, "R8 service blocks when not nested");
        tick(1); is_master = 1; nested_mode = 1; settle();
        chk(1, 2, "R8 nested master ignores line 2 service");
        tick(1); is_master = 0; settle();
        chk(0, 0, "R8 non-master keeps line 2 service");

        tick(3);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule